// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds a running calendar made of seven packed-BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year counted from 1970, so it covers 1970 to 2069. Software prepares a new time by writing a set of staging registers through a simple synchronous register bus. Writing the update trigger then copies all seven staged fields into the live counters on one clock edge. The live time can never show a mix of old and new fields.

An external prescaler supplies a one-cycle strobe once per second. Each strobe advances the calendar and carries through every field. Days use the correct length for each month. February is 28 or 29 days long according to a leap flag that software writes together with the year. Hours always count in 24-hour form.

Top module: `bcd_cal_top`

## Requirements
- R1: After reset the live time reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0x0, day 0x01, month 0x01, year 0x00 with the leap flag clear.
- R2: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 update trigger, 8 control. Each time field keeps only its own low bits: seconds and minutes keep 7 bits, hours and day keep 6, weekday keeps 3, month keeps 5 and year keeps 8. Bit 15 of the year register holds the leap flag. All other bits read as 0.
- R3: A write to a time field goes only to its staging register. Reads of addresses 0 to 6 return the live counters, so a staged write leaves the value read back unchanged until a load.
- R4: A write to address 7 with bit 15 set loads all seven staged fields and the leap flag into the live counters at that clock edge. A write to address 7 with bit 15 clear has no effect.
- R5: Each tick advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and increments minutes.
- R6: Minutes 0x59 wraps to 0x00 and increments hours. Hours 0x23 wraps to 0x00 and increments both the day and the weekday. The weekday counts 0 to 6 and then wraps to 0.
- R7: The day wraps to 0x01 and the month increments after these last days: day 0x30 in April, June, September and November; day 0x31 in the other long months; day 0x28 in February with the leap flag clear; day 0x29 in February with the leap flag set.
- R8: Month 0x12 wraps to 0x01 and increments the year. Year 0x99 wraps to 0x00. The leap flag is left unchanged by any rollover.
- R9: Address 7 always reads 0. Address 8 always reads 0x0001, meaning 24-hour mode, and writes to it are ignored. Unmapped addresses read 0.
- R10: A tick in the same cycle as a trigger load is dropped. The live time equals exactly the staged values after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| busWrEn | input | 1 | Register write enable |
| busAddr | input | ADDR_W | Register address for reads and writes |
| busWrData | input | DATA_W | Register write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |

## Verification
The hardest state to reach is a full cascade on a single tick, where seconds through year all wrap at once. A cascade where February ends under each setting of the leap flag is equally hard. Through the ports, these states are reachable only by loading a chosen time with the trigger and then ticking. The stimulus therefore loads directed times one second before each kind of month end and the year end. It then adds random valid times that are skewed toward 23:59:5x, so that random ticks cross day boundaries often. A load that collides with a tick is driven on purpose in the same cycle.

// File: rtl/bcal_pkg.sv
package bcal_pkg;
  localparam int SEC_W   = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int WDAY_W  = 3;
  localparam int MDAY_W  = 6;
  localparam int MON_W   = 5;
  localparam int YEAR_W  = 8;
  localparam int FIELD_NUM = 7;

  // address order matters: trigger sits right after the seven time fields
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_MDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_TRIG = FIELD_NUM;
  localparam int IDX_CTRL = FIELD_NUM + 1;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic [WDAY_W-1:0] wday;
    logic [MDAY_W-1:0] mday;
    logic [MON_W-1:0]  mon;
    logic [YEAR_W-1:0] year;
    logic              leap;
  } calTime_t;

  typedef struct packed {
    logic [FIELD_NUM-1:0] stageWe;
    logic                 loadNow;
    logic                 advance;
  } calStrobe_t;
endpackage

// File: rtl/bcal_ctrl.sv
module bcal_ctrl
  import bcal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              trigBit,
  input  logic              tick,
  output calStrobe_t        strobes
);
  logic [FIELD_NUM-1:0] fieldHit;

  for (genvar i = 0; i < FIELD_NUM; i++) begin : g_hit
    assign fieldHit[i] = busWrEn && (busAddr == ADDR_W'(i));
  end

  logic loadReq;
  assign loadReq = busWrEn && (busAddr == ADDR_W'(IDX_TRIG)) && trigBit;

  always_comb begin
    strobes.stageWe = fieldHit;
    strobes.loadNow = loadReq;
    // a load and a tick on the same edge: the load wins, the tick is lost
    strobes.advance = tick && !loadReq;
  end
endmodule

// File: rtl/bcal_datapath.sv
module bcal_datapath
  import bcal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output calTime_t          liveTime,
  output calTime_t          stageTime
);
  localparam int FLAG_BIT = DATA_W - 1;
  localparam calTime_t RESET_TIME = '{sec: '0, min: '0, hour: '0, wday: '0,
                                      mday: MDAY_W'(1), mon: MON_W'(1),
                                      year: '0, leap: 1'b0};

  logic unusedWrBits;
  assign unusedWrBits = ^busWrData[FLAG_BIT-1:YEAR_W];

  function automatic logic [7:0] bcdStep(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] lastDay(input logic [MON_W-1:0] m, input logic lp);
    case (m)
      MON_W'(5'h02): return lp ? 8'h29 : 8'h28;
      MON_W'(5'h04), MON_W'(5'h06), MON_W'(5'h09), MON_W'(5'h11): return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // staging registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageTime <= RESET_TIME;
    end else begin
      if (strobes.stageWe[IDX_SEC])  stageTime.sec  <= busWrData[SEC_W-1:0];
      if (strobes.stageWe[IDX_MIN])  stageTime.min  <= busWrData[MIN_W-1:0];
      if (strobes.stageWe[IDX_HOUR]) stageTime.hour <= busWrData[HOUR_W-1:0];
      if (strobes.stageWe[IDX_WDAY]) stageTime.wday <= busWrData[WDAY_W-1:0];
      if (strobes.stageWe[IDX_MDAY]) stageTime.mday <= busWrData[MDAY_W-1:0];
      if (strobes.stageWe[IDX_MON])  stageTime.mon  <= busWrData[MON_W-1:0];
      if (strobes.stageWe[IDX_YEAR]) begin
        stageTime.year <= busWrData[YEAR_W-1:0];
        stageTime.leap <= busWrData[FLAG_BIT];
      end
    end
  end

  // carry chain for one second
  calTime_t nextTime;
  logic [7:0] secInc, minInc, hourInc, mdayInc, monInc, yearInc;

  always_comb begin
    secInc  = bcdStep(8'(liveTime.sec));
    minInc  = bcdStep(8'(liveTime.min));
    hourInc = bcdStep(8'(liveTime.hour));
    mdayInc = bcdStep(8'(liveTime.mday));
    monInc  = bcdStep(8'(liveTime.mon));
    yearInc = bcdStep(liveTime.year);
    nextTime = liveTime;
    if (liveTime.sec < SEC_W'(7'h59)) begin
      nextTime.sec = secInc[SEC_W-1:0];
    end else begin
      nextTime.sec = '0;
      if (liveTime.min < MIN_W'(7'h59)) begin
        nextTime.min = minInc[MIN_W-1:0];
      end else begin
        nextTime.min = '0;
        if (liveTime.hour < HOUR_W'(6'h23)) begin
          nextTime.hour = hourInc[HOUR_W-1:0];
        end else begin
          nextTime.hour = '0;
          nextTime.wday = (liveTime.wday >= WDAY_W'(6)) ? '0 : liveTime.wday + WDAY_W'(1);
          if (8'(liveTime.mday) < lastDay(liveTime.mon, liveTime.leap)) begin
            nextTime.mday = mdayInc[MDAY_W-1:0];
          end else begin
            nextTime.mday = MDAY_W'(1);
            if (liveTime.mon < MON_W'(5'h12)) begin
              nextTime.mon = monInc[MON_W-1:0];
            end else begin
              nextTime.mon = MON_W'(1);
              nextTime.year = (liveTime.year >= 8'h99) ? '0 : yearInc;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                liveTime <= RESET_TIME;
    else if (strobes.loadNow) liveTime <= stageTime;
    else if (strobes.advance) liveTime <= nextTime;
  end

  // read mux: live values only
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(IDX_SEC):  busRdData = DATA_W'(liveTime.sec);
      ADDR_W'(IDX_MIN):  busRdData = DATA_W'(liveTime.min);
      ADDR_W'(IDX_HOUR): busRdData = DATA_W'(liveTime.hour);
      ADDR_W'(IDX_WDAY): busRdData = DATA_W'(liveTime.wday);
      ADDR_W'(IDX_MDAY): busRdData = DATA_W'(liveTime.mday);
      ADDR_W'(IDX_MON):  busRdData = DATA_W'(liveTime.mon);
      ADDR_W'(IDX_YEAR): begin
        busRdData = DATA_W'(liveTime.year);
        busRdData[FLAG_BIT] = liveTime.leap;
      end
      ADDR_W'(IDX_CTRL): busRdData = DATA_W'(1);
      default:           busRdData = '0;
    endcase
  end
endmodule

// File: rtl/bcd_cal_top.sv
module bcd_cal_top
  import bcal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  calStrobe_t strobes;
  calTime_t   liveTime;
  calTime_t   stageTime;

  bcal_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .trigBit (busWrData[DATA_W-1]),
    .tick    (tick),
    .strobes (strobes)
  );

  bcal_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .liveTime  (liveTime),
    .stageTime (stageTime)
  );
endmodule

// File: rtl/bcal_checker.sv
module bcal_checker
  import bcal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input calStrobe_t        strobes,
  input calTime_t          liveTime,
  input calTime_t          stageTime
);
  AST_LOAD_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> liveTime == $past(stageTime)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadNow && !strobes.advance) |=> $stable(liveTime)); // R3

  AST_TICK_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (tick && busWrEn && busAddr == ADDR_W'(IDX_TRIG) && busWrData[DATA_W-1])
      |=> liveTime == $past(stageTime)); // R10

  AST_SEC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && liveTime.sec < SEC_W'(7'h59))
      |=> (liveTime.min == $past(liveTime.min)) && (liveTime.sec != $past(liveTime.sec))); // R5

  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && liveTime.sec == SEC_W'(7'h59) && liveTime.min == MIN_W'(7'h59)
      && liveTime.hour == HOUR_W'(6'h23))
      |=> (liveTime.hour == '0) && (liveTime.min == '0)); // R6

  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(IDX_TRIG)) |-> (busRdData == '0)); // R9
endmodule

bind bcd_cal_top bcal_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .strobes   (strobes),
  .liveTime  (liveTime),
  .stageTime (stageTime)
);

// File: tb/bcd_cal_top_bench.sv
`timescale 1ns/1ps
module bcd_cal_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // expected time, binary
  int eSec, eMin, eHour, eWday, eDay, eMon, eYear;
  bit eLeap;

  bcd_cal_top u_bcd_cal_top (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] toBcd(input int v);
    return 16'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int monLen(input int m, input bit lp);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic bit isLeap(input int yOff);
    int y = 1970 + yOff;
    return (y % 4 == 0 && y % 100 != 0) || (y % 400 == 0);
  endfunction

  task automatic modelStep();
    eSec++;
    if (eSec == 60) begin
      eSec = 0; eMin++;
      if (eMin == 60) begin
        eMin = 0; eHour++;
        if (eHour == 24) begin
          eHour = 0;
          eWday = (eWday + 1) % 7;
          eDay++;
          if (eDay > monLen(eMon, eLeap)) begin
            eDay = 1; eMon++;
            if (eMon == 13) begin
              eMon = 1;
              eYear = (eYear + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic readReg(input int a, output logic [15:0] v);
    busAddr = 4'(a);
    #0.2;
    v = busRdData;
  endtask

  task automatic checkReg(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    readReg(a, v);
    check(req, v, exp);
  endtask

  task automatic checkAll(input string req);
    checkReg(req, 0, toBcd(eSec));
    checkReg(req, 1, toBcd(eMin));
    checkReg(req, 2, toBcd(eHour));
    checkReg(req, 3, toBcd(eWday));
    checkReg(req, 4, toBcd(eDay));
    checkReg(req, 5, toBcd(eMon));
    checkReg(req, 6, toBcd(eYear) | (eLeap ? 16'h8000 : 16'h0000));
  endtask

  task automatic writeReg(input int a, input logic [15:0] d, input bit withTick = 1'b0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 4'(a); busWrData = d; tick = withTick;
    @(negedge clk);
    busWrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic setTime(input int s, input int mi, input int h, input int w,
                         input int d, input int mo, input int y, input bit lp,
                         input bit withTick = 1'b0);
    writeReg(0, toBcd(s));
    writeReg(1, toBcd(mi));
    writeReg(2, toBcd(h));
    writeReg(3, toBcd(w));
    writeReg(4, toBcd(d));
    writeReg(5, toBcd(mo));
    writeReg(6, toBcd(y) | (lp ? 16'h8000 : 16'h0000));
    writeReg(7, 16'h8000, withTick);
    eSec = s; eMin = mi; eHour = h; eWday = w; eDay = d; eMon = mo; eYear = y; eLeap = lp;
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      modelStep();
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    eSec = 0; eMin = 0; eHour = 0; eWday = 0; eDay = 1; eMon = 1; eYear = 0; eLeap = 0;
    checkAll("R1");
    // R9 trigger and control readback
    checkReg("R9", 7, 16'h0000);
    checkReg("R9", 8, 16'h0001);
    writeReg(8, 16'h0000);
    checkReg("R9 ctrl write ignored", 8, 16'h0001);
    checkReg("R9 unmapped", 9, 16'h0000);

    // R2 field masking
    for (int a = 0; a < 7; a++) writeReg(a, 16'hFFFF);
    writeReg(7, 16'h8000);
    checkReg("R2 sec", 0, 16'h007F);
    checkReg("R2 min", 1, 16'h007F);
    checkReg("R2 hour", 2, 16'h003F);
    checkReg("R2 wday", 3, 16'h0007);
    checkReg("R2 mday", 4, 16'h003F);
    checkReg("R2 mon", 5, 16'h001F);
    checkReg("R2 year", 6, 16'h80FF);
    checkReg("R2 trig after load", 7, 16'h0000);

    // R3 staged write invisible, R4 trigger with bit 15 clear has no effect
    setTime(10, 20, 8, 2, 15, 6, 33, 0);
    checkAll("R4 load");
    writeReg(0, toBcd(42));
    checkAll("R3 staged only");
    writeReg(7, 16'h7FFF);
    checkAll("R4 trigger bit clear");
    writeReg(7, 16'h8000);
    eSec = 42;
    checkAll("R4 trigger bit set");

    // R5 simple ticks and minute carry
    doTicks(1);
    checkAll("R5 single tick");
    doTicks(17);
    checkAll("R5 minute carry");

    // R10 tick colliding with load
    setTime(5, 5, 5, 5, 5, 5, 5, 0, 1'b1);
    checkAll("R10 tick dropped");

    // R6 hour and weekday wrap
    setTime(59, 59, 23, 6, 10, 3, 40, 0);
    doTicks(1);
    checkAll("R6 day wrap weekday 6->0");
    // R7 month ends
    setTime(59, 59, 23, 1, 28, 2, 25, 0);
    doTicks(1);
    checkAll("R7 Feb 28 no leap");
    setTime(59, 59, 23, 1, 28, 2, 30, 1);
    doTicks(1);
    checkAll("R7 Feb 28 leap -> 29");
    setTime(59, 59, 23, 2, 29, 2, 30, 1);
    doTicks(1);
    checkAll("R7 Feb 29 leap");
    setTime(59, 59, 23, 3, 30, 4, 12, 0);
    doTicks(1);
    checkAll("R7 Apr 30");
    setTime(59, 59, 23, 3, 30, 1, 12, 0);
    doTicks(1);
    checkAll("R7 Jan 30 -> 31");
    setTime(59, 59, 23, 4, 31, 1, 12, 0);
    doTicks(1);
    checkAll("R7 Jan 31");
    // R8 year ends
    setTime(59, 59, 23, 5, 31, 12, 45, 0);
    doTicks(1);
    checkAll("R8 Dec 31");
    setTime(59, 59, 23, 0, 31, 12, 99, 1);
    doTicks(1);
    checkAll("R8 year 99 wrap leap kept");

    // random valid times skewed toward day ends
    for (int it = 0; it < 40; it++) begin
      int y  = int'($urandom_range(0, 99));
      bit lp = isLeap(y);
      int mo = int'($urandom_range(1, 12));
      int d  = int'($urandom_range(1, monLen(mo, lp)));
      int h  = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
      int mi = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      int s  = int'($urandom_range(0, 59));
      if ($urandom_range(0, 3) == 0) d = monLen(mo, lp);
      setTime(s, mi, h, int'($urandom_range(0, 6)), d, mo, y, lp);
      doTicks(int'($urandom_range(1, 200)));
      checkAll("R5 R6 R7 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule